// File: doc/BRIEF.md
# Serial Controller Interrupt Flag Logic

This block keeps the interrupt status flags of a quad-SPI style serial controller. The controller core sends single-cycle event strobes: transmit holding register written, holding register moved into the shifter, shifter drained, receive register loaded from the shifter, receive register read, chip select rising, and instruction end. A level input tells the block whether the controller is enabled.

There are two kinds of flags. Three are sticky event flags: overrun, chip-select rise and instruction end. Software clears them by writing ones to the status word. The other three follow the data registers: receive-full, transmit-holding-empty and transmit-complete. These set and clear from core activity alone.

Software reads the status word over a simple synchronous bus, with the read data returned one cycle after the request. A per-bit mask input selects which flags drive a single registered interrupt line.

Top module: `sif_flag_unit`

## Requirements
- R1: After reset the status word, the read data and the interrupt output are all zero.
- R2: A read with the address at the status offset (0x1C) returns, on the next cycle, the status word as it stood in the request cycle. The bit positions are: receive-full 0, holding-empty 1, transmit-complete 2, overrun 3, chip-select rise 8, instruction end 10. Every other bit reads 0. A read at any other address returns 0.
- R3: A write at the status offset clears overrun (bit 3), chip-select rise (bit 8) or instruction end (bit 10) wherever the data bit is 1. A 0 data bit, a write to bits 0 to 2 or to reserved bits, and a write at any other address change nothing.
- R4: When a set event and a write-one clear hit the same sticky flag in the same cycle, the flag ends up set.
- R5: Receive-full sets on a receive load and clears on a receive read. A load and a read in the same cycle leave it set.
- R6: Overrun sets when a receive load arrives while receive-full is 1 and no receive read occurs in that cycle.
- R7: Holding-empty is 0 while the controller is disabled. It becomes 1 on the cycle after enable is seen high following a disabled cycle. It clears on a transmit write, which wins over a same-cycle shifter load. It otherwise sets on a shifter load.
- R8: Transmit-complete clears on a transmit write. Otherwise it sets on a shifter-drained strobe only while holding-empty is 1. The core raises that strobe after any configured transfer delay.
- R9: The chip-select rise and instruction end flags set on the cycle after their strobes.
- R10: The interrupt output equals, one cycle later, the OR over all bits of the status word ANDed with the mask input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Controller enabled level |
| tx_wr_i | input | 1 | Strobe: transmit holding register written |
| tx_load_i | input | 1 | Strobe: holding register moved into shifter |
| tx_done_i | input | 1 | Strobe: shifter drained, delay elapsed |
| rx_load_i | input | 1 | Strobe: receive register loaded from shifter |
| rx_read_i | input | 1 | Strobe: receive register read |
| cs_rise_i | input | 1 | Strobe: chip select rising edge |
| instr_end_i | input | 1 | Strobe: instruction ended |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the request |
| irq_mask_i | input | 32 | Per-bit interrupt enable |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The assertions assume only that reset is applied before the first checked cycle and that the strobes are sampled once per clock. They make no assumption about which strobes may occur together, so they hold for combinations a real core never produces, such as a drain together with a shifter load. The bench uses this freedom. It sweeps every combination of the seven strobes while the block is enabled, each with a write-one pattern, and it also runs directed cases for the disabled state, same-cycle set against clear, and accesses at other addresses. Every result is compared with a bench model of the flag rules.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int WORD_W   = 32;
    localparam int POS_RXC  = 0;
    localparam int POS_DRE  = 1;
    localparam int POS_TXC  = 2;
    localparam int POS_ERR  = 3;
    localparam int POS_CSR  = 8;
    localparam int POS_IEND = 10;
    localparam int STICKY_N = 3;
    // sticky slot order: 0 overrun, 1 chip-select rise, 2 instruction end
    localparam logic [WORD_W-1:0] VALID_MASK =
        (WORD_W'(1) << POS_RXC) | (WORD_W'(1) << POS_DRE) | (WORD_W'(1) << POS_TXC) |
        (WORD_W'(1) << POS_ERR) | (WORD_W'(1) << POS_CSR) | (WORD_W'(1) << POS_IEND);

    typedef struct packed {
        logic rxc;
        logic dre;
        logic txc;
        logic en_seen;
    } data_st_t;

    function automatic int sticky_pos(input int slot);
        case (slot)
            0:       return POS_ERR;
            1:       return POS_CSR;
            default: return POS_IEND;
        endcase
    endfunction
endpackage

// File: rtl/sif_sticky_bank.sv
module sif_sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    // set has priority over a same-cycle clear
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sif_data_flags.sv
module sif_data_flags
    import sif_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tx_wr_i,
    input  logic tx_load_i,
    input  logic tx_done_i,
    input  logic rx_load_i,
    input  logic rx_read_i,
    output logic rxc_o,
    output logic dre_o,
    output logic txc_o,
    output logic overrun_set_o
);
    data_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.en_seen = en_i;

        if (rx_load_i)      st_d.rxc = 1'b1;
        else if (rx_read_i) st_d.rxc = 1'b0;

        if (!en_i)                         st_d.dre = 1'b0;
        else if (tx_wr_i)                  st_d.dre = 1'b0;
        else if (tx_load_i || !st_q.en_seen) st_d.dre = 1'b1;

        if (tx_wr_i)                    st_d.txc = 1'b0;
        else if (tx_done_i && st_q.dre) st_d.txc = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rxc_o         = st_q.rxc;
    assign dre_o         = st_q.dre;
    assign txc_o         = st_q.txc;
    assign overrun_set_o = rx_load_i & st_q.rxc & ~rx_read_i;
endmodule

// File: rtl/sif_bus_port.sv
module sif_bus_port
    import sif_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h1C
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic              bus_re_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] w1c_o,
    output logic [WORD_W-1:0] bus_rdata_o
);
    logic              hit;
    logic [WORD_W-1:0] rdata_d, rdata_q;

    always_comb begin
        hit     = (bus_addr_i == OFFSET);
        w1c_o   = (bus_we_i && hit) ? bus_wdata_i : '0;
        rdata_d = (bus_re_i && hit) ? (word_i & VALID_MASK) : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/sif_irq_gen.sv
module sif_irq_gen #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic irq_d, irq_q;

    always_comb irq_d = |(flags_i & mask_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/sif_flag_unit.sv
module sif_flag_unit
    import sif_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h1C
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              tx_wr_i,
    input  logic              tx_load_i,
    input  logic              tx_done_i,
    input  logic              rx_load_i,
    input  logic              rx_read_i,
    input  logic              cs_rise_i,
    input  logic              instr_end_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_re_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [31:0]       irq_mask_i,
    output logic              irq_o
);
    logic                rxc, dre, txc, overrun_set;
    logic [STICKY_N-1:0] sticky_set, sticky_clr, sticky_q;
    logic [WORD_W-1:0]   w1c, status_w;
    logic                w1c_unused;

    sif_data_flags u_data (
        .clk_i, .rst_ni, .en_i, .tx_wr_i, .tx_load_i, .tx_done_i,
        .rx_load_i, .rx_read_i,
        .rxc_o(rxc), .dre_o(dre), .txc_o(txc), .overrun_set_o(overrun_set)
    );

    assign sticky_set = {instr_end_i, cs_rise_i, overrun_set};

    for (genvar s = 0; s < STICKY_N; s++) begin : g_clr
        assign sticky_clr[s] = w1c[sticky_pos(s)];
    end

    sif_sticky_bank #(.N(STICKY_N)) u_sticky (
        .clk_i, .rst_ni, .set_i(sticky_set), .clr_i(sticky_clr), .flag_o(sticky_q)
    );

    always_comb begin
        status_w              = '0;
        status_w[POS_RXC]     = rxc;
        status_w[POS_DRE]     = dre;
        status_w[POS_TXC]     = txc;
        for (int s = 0; s < STICKY_N; s++) status_w[sticky_pos(s)] = sticky_q[s];
    end

    assign w1c_unused = ^(w1c & ~VALID_MASK) ^ w1c[POS_RXC] ^ w1c[POS_DRE] ^ w1c[POS_TXC];

    sif_bus_port #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_bus (
        .clk_i, .rst_ni, .bus_addr_i, .bus_we_i, .bus_wdata_i, .bus_re_i,
        .word_i(status_w), .w1c_o(w1c), .bus_rdata_o
    );

    sif_irq_gen #(.W(WORD_W)) u_irq (
        .clk_i, .rst_ni, .flags_i(status_w), .mask_i(irq_mask_i), .irq_o
    );
endmodule

// File: rtl/sif_flag_unit_chk.sv
module sif_flag_unit_chk
    import sif_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              tx_wr_i,
    input logic              rx_load_i,
    input logic              rx_read_i,
    input logic              cs_rise_i,
    input logic              instr_end_i,
    input logic [WORD_W-1:0] status_w,
    input logic [WORD_W-1:0] bus_rdata_o,
    input logic [WORD_W-1:0] irq_mask_i,
    input logic              irq_o
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdata_o & ~VALID_MASK) == '0);
    // R5
    rxc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_load_i |=> status_w[POS_RXC]);
    // R6
    overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_load_i && status_w[POS_RXC] && !rx_read_i) |=> status_w[POS_ERR]);
    // R7
    dre_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !status_w[POS_DRE]);
    // R8
    txc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_wr_i |=> !status_w[POS_TXC]);
    // R8
    txc_needs_dre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_w[POS_TXC]) |-> $past(status_w[POS_DRE]));
    // R9
    csr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_rise_i |=> status_w[POS_CSR]);
    // R9
    iend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_end_i |=> status_w[POS_IEND]);
    // R10
    irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|(status_w & irq_mask_i))));
endmodule

bind sif_flag_unit sif_flag_unit_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tx_wr_i(tx_wr_i),
    .rx_load_i(rx_load_i), .rx_read_i(rx_read_i), .cs_rise_i(cs_rise_i),
    .instr_end_i(instr_end_i), .status_w(status_w), .bus_rdata_o(bus_rdata_o),
    .irq_mask_i(irq_mask_i), .irq_o(irq_o)
);

// File: tb/sif_flag_unit_bench.sv
`timescale 1ns/1ps
module sif_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [6:0]  ev = '0;   // [0]tx_wr [1]tx_load [2]tx_done [3]rx_load [4]rx_read [5]cs_rise [6]instr_end
    logic [7:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0, mask = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench model of the flags
    logic m_rxc = 0, m_dre = 0, m_txc = 0, m_err = 0, m_csr = 0, m_ie = 0, m_enp = 0;

    always #2.5 clk = ~clk;

    sif_flag_unit u_sif_flag_unit (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .tx_wr_i(ev[0]), .tx_load_i(ev[1]), .tx_done_i(ev[2]),
        .rx_load_i(ev[3]), .rx_read_i(ev[4]), .cs_rise_i(ev[5]), .instr_end_i(ev[6]),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_re_i(re),
        .bus_rdata_o(rdata), .irq_mask_i(mask), .irq_o(irq)
    );

    function automatic logic [31:0] m_word();
        return {21'b0, m_ie, 1'b0, m_csr, 4'b0, m_err, m_txc, m_dre, m_rxc};
    endfunction

    task automatic m_step();
        logic [31:0] clr;
        logic n_rxc, n_dre, n_txc;
        clr   = (we && addr == 8'h1C) ? wdata : 32'h0;
        n_rxc = ev[3] ? 1'b1 : (ev[4] ? 1'b0 : m_rxc);
        n_dre = !en ? 1'b0 : ev[0] ? 1'b0 : (ev[1] || !m_enp) ? 1'b1 : m_dre;
        n_txc = ev[0] ? 1'b0 : (ev[2] && m_dre) ? 1'b1 : m_txc;
        m_err = (ev[3] && m_rxc && !ev[4]) || (m_err && !clr[3]);
        m_csr = ev[5] || (m_csr && !clr[8]);
        m_ie  = ev[6] || (m_ie && !clr[10]);
        m_rxc = n_rxc; m_dre = n_dre; m_txc = n_txc; m_enp = en;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with given strobes and optional write
    task automatic cyc(input logic [6:0] e, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        ev = e; we = w; re = 1'b0; addr = a; wdata = d;
        @(posedge clk); #1;
        if (rst_n) m_step();
    endtask

    // read at address a, compare read data and interrupt
    task automatic rd(input string tag, input logic [7:0] a);
        logic [31:0] exp;
        @(negedge clk);
        ev = '0; we = 1'b0; re = 1'b1; addr = a;
        exp = (a == 8'h1C) ? m_word() : 32'h0;
        @(posedge clk); #1;
        chk(tag, rdata, exp);
        chk({tag, " R10 irq"}, {31'b0, irq}, {31'b0, |(m_word() & mask)});
        m_step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R1 rdata at reset", rdata, 32'h0);
        chk("R1 irq at reset", {31'b0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        mask = 32'hFFFF_FFFF;
        rd("R1 status after reset", 8'h1C);

        // R7 disabled: shifter load does not raise holding-empty
        cyc(7'b000_0010, 1'b0, 8'h0, 32'h0);
        rd("R7 disabled dre", 8'h1C);
        en = 1'b1;
        cyc(7'b0, 1'b0, 8'h0, 32'h0);
        rd("R7 dre after enable", 8'h1C);
        cyc(7'b000_0001, 1'b0, 8'h0, 32'h0);
        rd("R7 dre cleared by write", 8'h1C);
        cyc(7'b000_0100, 1'b0, 8'h0, 32'h0);
        rd("R8 no txc while holding full", 8'h1C);
        cyc(7'b000_0010, 1'b0, 8'h0, 32'h0);
        cyc(7'b000_0100, 1'b0, 8'h0, 32'h0);
        rd("R8 txc after drain", 8'h1C);

        // R5 / R6
        cyc(7'b000_1000, 1'b0, 8'h0, 32'h0);
        rd("R5 rxc set", 8'h1C);
        cyc(7'b001_1000, 1'b0, 8'h0, 32'h0);
        rd("R5 load and read keep rxc, R6 no overrun", 8'h1C);
        cyc(7'b000_1000, 1'b0, 8'h0, 32'h0);
        rd("R6 overrun set", 8'h1C);

        // R9 then R3 / R4 / R2
        cyc(7'b110_0000, 1'b0, 8'h0, 32'h0);
        rd("R9 csr and iend set", 8'h1C);
        rd("R2 other address reads zero", 8'h18);
        cyc(7'b0, 1'b1, 8'h18, 32'hFFFF_FFFF);
        rd("R3 write elsewhere ignored", 8'h1C);
        cyc(7'b0, 1'b1, 8'h1C, 32'hFFFF_F8F7);
        rd("R3 zero bits and auto flags ignored", 8'h1C);
        cyc(7'b010_0000, 1'b1, 8'h1C, 32'h0000_0508);
        rd("R4 set beats clear", 8'h1C);
        cyc(7'b0, 1'b1, 8'h1C, 32'h0000_0108);
        rd("R3 csr and overrun cleared", 8'h1C);
        mask = 32'h0;
        rd("R10 masked irq low", 8'h1C);

        // sweep of every strobe combination, enabled
        for (int i = 0; i < 128; i++) begin
            mask = 32'h1 << (i % 11);
            cyc(7'(i), 1'b1, 8'h1C, {21'b0, i[4], 1'b0, i[2], 4'b0, i[6], 3'b111});
            rd("R3/R4/R5/R6/R7/R8/R9 sweep", 8'h1C);
        end
        // R7 disable drops holding-empty
        en = 1'b0;
        cyc(7'b000_0010, 1'b0, 8'h0, 32'h0);
        rd("R7 dre off when disabled", 8'h1C);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule